// File: doc/BRIEF.md
# Sub-pixel motion-compensation interpolator

This block forms the inter-prediction samples of one 4x4 luma block and the two matching 2x2 chroma blocks. The caller supplies a 9x9 window of 8-bit reference luma samples, the 2-bit horizontal and vertical fractions of the luma motion vector, one 3x3 window for each chroma plane, and the two 3-bit chroma fractions. The block returns the 16 predicted luma samples and the 2x2 blue-difference and red-difference predictions together in one output word.

Luma half samples come from a six-tap filter. The centre half sample is filtered a second time from the unrounded horizontal sums. Quarter samples are rounded averages of two neighbouring integer or half samples. All 16 luma positions are computed in parallel. The caller only has to fill the part of the window that the fraction needs: the central 4x4 for an integer vector, 4 rows by 9 columns for a horizontal-only fraction, 9 rows by 4 columns for a vertical-only fraction, and the full 9x9 otherwise. Chroma uses bilinear weights at eighth-sample precision and finishes earlier, so its result waits in delay registers until the luma result is ready.

Inputs and outputs use valid/ready handshakes. The block is a three-register pipeline that stalls as a whole when the output is not taken.

Top module: `mc_interp`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low and in_ready is high until a transfer is accepted.
- R2: Encodings. Luma window sample (row r, column c), with r and c from 0 to 8, sits at bits [(9r+c)*8 +: 8]. The integer sample G of output (i,j) is window (i+2, j+2). Output luma (i,j) sits at bits [(4i+j)*8 +: 8]. A chroma window sample (r,c) sits at [(3r+c)*8 +: 8], and chroma output (i,k) sits at [(2i+k)*8 +: 8]. Fractions are in quarter (luma) or eighth (chroma) sample units, with x horizontal and y vertical.
- R3: The half samples b (x=2, y=0) and h (x=0, y=2) equal clip((E - 5F + 20G + 20H - 5I + J + 16) >> 5) over the six integer samples along the row or column. clip limits the result to 0..255.
- R4: The centre sample j (x=2, y=2) applies the same taps vertically to six unrounded horizontal sums, then gives clip((sum + 512) >> 10).
- R5: Every quarter position with exactly one odd fraction is the rounded mean (p + q + 1) >> 1 of its two nearest integer or half samples (G, H, M, b, h, s, m, j).
- R6: The diagonal positions (both fractions odd) are the rounded mean of the two nearest half samples among b, h, s, m.
- R7: For fraction (0,0) each output equals its integer sample G.
- R8: Window samples outside the region that the fraction needs do not change the luma output.
- R9: Each chroma output equals ((8-dx)(8-dy)A + dx(8-dy)B + (8-dx)dy C + dx dy D + 32) >> 6. A is window (i,k), B is to its right, C is below it and D is diagonal to it.
- R10: An input accepted on a clock edge appears at the output, with out_valid high, after the second following edge when the output is not stalled.
- R11: While out_valid is high and out_ready is low, the output is held unchanged and no data is dropped. When the pipeline is full, in_ready is low. After release, results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_fx | input | 2 | Luma horizontal fraction |
| in_fy | input | 2 | Luma vertical fraction |
| in_luma_win | input | 648 | 9x9 luma reference window |
| in_cfx | input | 3 | Chroma horizontal fraction |
| in_cfy | input | 3 | Chroma vertical fraction |
| in_cb_win | input | 72 | 3x3 blue-difference window |
| in_cr_win | input | 72 | 3x3 red-difference window |
| out_valid | output | 1 | Prediction available |
| out_ready | input | 1 | Consumer takes the prediction |
| out_luma | output | 128 | 4x4 predicted luma |
| out_cb | output | 32 | 2x2 predicted blue-difference |
| out_cr | output | 32 | 2x2 predicted red-difference |

## Verification
Each result, luma and both chroma blocks alike, is due after the second clock edge that follows the accepting edge. The bench offers one input per transfer and samples on falling edges. It confirms that out_valid is still low one and two falling edges after acceptance, then checks valid and all three data fields together on the third falling edge. In the back-pressure test the bench fills all three stages, holds the output for several cycles, and then reads one result per falling edge as the stall releases. A behavioural model built from the requirement formulas supplies every expected value.

// File: rtl/mc_interp.sv
module mc_interp #(
  parameter int PIX_W = 8
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_fx,
  input  logic [1:0]          in_fy,
  input  logic [81*PIX_W-1:0] in_luma_win,
  input  logic [2:0]          in_cfx,
  input  logic [2:0]          in_cfy,
  input  logic [9*PIX_W-1:0]  in_cb_win,
  input  logic [9*PIX_W-1:0]  in_cr_win,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [16*PIX_W-1:0] out_luma,
  output logic [4*PIX_W-1:0]  out_cb,
  output logic [4*PIX_W-1:0]  out_cr
);
  localparam int LW     = 9;
  localparam int BK     = 4;
  localparam int HB     = BK + 1;
  localparam int CW     = 3;
  localparam int CB     = 2;
  localparam int RAW_W  = PIX_W + 7;
  localparam int ACC_W  = PIX_W + 14;
  localparam int CACC_W = PIX_W + 8;
  localparam int PMAX   = (1 << PIX_W) - 1;
  localparam int RND1   = 16;
  localparam int SH1    = 5;
  localparam int RND2   = 512;
  localparam int SH2    = 10;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [RAW_W-1:0] raw_t;
  typedef logic [PIX_W-1:0]        pix_t;

  function automatic acc_t ext(pix_t p);
    return acc_t'(p);
  endfunction

  function automatic acc_t tap6(acc_t p0, acc_t p1, acc_t p2, acc_t p3, acc_t p4, acc_t p5);
    return (p0 + p5) - acc_t'(5) * (p1 + p4) + acc_t'(20) * (p2 + p3);
  endfunction

  function automatic pix_t clip(acc_t v);
    if (v < 0) return '0;
    if (v > acc_t'(PMAX)) return '1;
    return v[PIX_W-1:0];
  endfunction

  function automatic pix_t avg(pix_t x, pix_t y);
    logic [PIX_W:0] s;
    s = {1'b0, x} + {1'b0, y} + (PIX_W+1)'(1);
    return s[PIX_W:1];
  endfunction

  function automatic pix_t bil(pix_t a, pix_t b, pix_t c, pix_t d, logic [2:0] dx, logic [2:0] dy);
    logic [CACC_W-1:0] ix, iy, jx, jy, s;
    jx = CACC_W'(dx);
    jy = CACC_W'(dy);
    ix = CACC_W'(8) - jx;
    iy = CACC_W'(8) - jy;
    s  = ix * iy * CACC_W'(a) + jx * iy * CACC_W'(b)
       + ix * jy * CACC_W'(c) + jx * jy * CACC_W'(d) + CACC_W'(32);
    return s[6 +: PIX_W];
  endfunction

  function automatic pix_t pick(logic [1:0] x, logic [1:0] y, pix_t g, pix_t hr, pix_t mb,
                                pix_t b, pix_t s, pix_t h, pix_t m, pix_t j);
    case ({x, y})
      4'b00_00: return g;
      4'b01_00: return avg(g, b);
      4'b10_00: return b;
      4'b11_00: return avg(hr, b);
      4'b00_01: return avg(g, h);
      4'b01_01: return avg(b, h);
      4'b10_01: return avg(b, j);
      4'b11_01: return avg(b, m);
      4'b00_10: return h;
      4'b01_10: return avg(h, j);
      4'b10_10: return j;
      4'b11_10: return avg(j, m);
      4'b00_11: return avg(mb, h);
      4'b01_11: return avg(h, s);
      4'b10_11: return avg(j, s);
      default:  return avg(m, s);
    endcase
  endfunction

  logic en;
  logic v1, v2;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  // stage 1: captured inputs
  logic [1:0]              fx1, fy1;
  logic [2:0]              cfx1, cfy1;
  logic [LW*LW*PIX_W-1:0]  lw1;
  logic [CW*CW*PIX_W-1:0]  cb1, cr1;

  always_ff @(posedge clk) begin
    if (en) begin
      fx1  <= in_fx;
      fy1  <= in_fy;
      cfx1 <= in_cfx;
      cfy1 <= in_cfy;
      lw1  <= in_luma_win;
      cb1  <= in_cb_win;
      cr1  <= in_cr_win;
    end
  end

  pix_t lp  [LW][LW];
  pix_t cbp [CW][CW];
  pix_t crp [CW][CW];
  acc_t rawc [LW][BK];
  pix_t bc  [HB][BK];
  pix_t hc  [BK][HB];
  pix_t cbc [CB][CB];
  pix_t crc [CB][CB];

  always_comb begin
    for (int r = 0; r < LW; r++)
      for (int c = 0; c < LW; c++)
        lp[r][c] = lw1[(r*LW+c)*PIX_W +: PIX_W];
    for (int r = 0; r < CW; r++)
      for (int c = 0; c < CW; c++) begin
        cbp[r][c] = cb1[(r*CW+c)*PIX_W +: PIX_W];
        crp[r][c] = cr1[(r*CW+c)*PIX_W +: PIX_W];
      end
    for (int r = 0; r < LW; r++)
      for (int c = 0; c < BK; c++)
        rawc[r][c] = tap6(ext(lp[r][c]), ext(lp[r][c+1]), ext(lp[r][c+2]),
                          ext(lp[r][c+3]), ext(lp[r][c+4]), ext(lp[r][c+5]));
    for (int r = 0; r < HB; r++)
      for (int c = 0; c < BK; c++)
        bc[r][c] = clip((rawc[r+2][c] + acc_t'(RND1)) >>> SH1);
    for (int r = 0; r < BK; r++)
      for (int c = 0; c < HB; c++)
        hc[r][c] = clip((tap6(ext(lp[r][c+2]), ext(lp[r+1][c+2]), ext(lp[r+2][c+2]),
                              ext(lp[r+3][c+2]), ext(lp[r+4][c+2]), ext(lp[r+5][c+2]))
                         + acc_t'(RND1)) >>> SH1);
    for (int i = 0; i < CB; i++)
      for (int k = 0; k < CB; k++) begin
        cbc[i][k] = bil(cbp[i][k], cbp[i][k+1], cbp[i+1][k], cbp[i+1][k+1], cfx1, cfy1);
        crc[i][k] = bil(crp[i][k], crp[i][k+1], crp[i+1][k], crp[i+1][k+1], cfx1, cfy1);
      end
  end

  // stage 2: half samples, unrounded sums, integers, finished chroma
  logic [1:0]         fx2, fy2;
  raw_t               raw2 [LW][BK];
  pix_t               b2   [HB][BK];
  pix_t               h2   [BK][HB];
  pix_t               g2   [HB][HB];
  logic [4*PIX_W-1:0] cb2, cr2;

  always_ff @(posedge clk) begin
    if (en) begin
      fx2 <= fx1;
      fy2 <= fy1;
      for (int r = 0; r < LW; r++)
        for (int c = 0; c < BK; c++)
          raw2[r][c] <= raw_t'(rawc[r][c]);
      for (int r = 0; r < HB; r++)
        for (int c = 0; c < BK; c++)
          b2[r][c] <= bc[r][c];
      for (int r = 0; r < BK; r++)
        for (int c = 0; c < HB; c++)
          h2[r][c] <= hc[r][c];
      for (int r = 0; r < HB; r++)
        for (int c = 0; c < HB; c++)
          g2[r][c] <= lp[r+2][c+2];
      for (int i = 0; i < CB; i++)
        for (int k = 0; k < CB; k++) begin
          cb2[(i*CB+k)*PIX_W +: PIX_W] <= cbc[i][k];
          cr2[(i*CB+k)*PIX_W +: PIX_W] <= crc[i][k];
        end
    end
  end

  pix_t jc   [BK][BK];
  pix_t pred [BK][BK];

  always_comb begin
    for (int i = 0; i < BK; i++)
      for (int c = 0; c < BK; c++) begin
        jc[i][c] = clip((tap6(acc_t'(raw2[i][c]),   acc_t'(raw2[i+1][c]), acc_t'(raw2[i+2][c]),
                              acc_t'(raw2[i+3][c]), acc_t'(raw2[i+4][c]), acc_t'(raw2[i+5][c]))
                         + acc_t'(RND2)) >>> SH2);
        pred[i][c] = pick(fx2, fy2, g2[i][c], g2[i][c+1], g2[i+1][c],
                          b2[i][c], b2[i+1][c], h2[i][c], h2[i][c+1], jc[i][c]);
      end
  end

  // stage 3: output register
  always_ff @(posedge clk) begin
    if (en) begin
      for (int i = 0; i < BK; i++)
        for (int c = 0; c < BK; c++)
          out_luma[(i*BK+c)*PIX_W +: PIX_W] <= pred[i][c];
      out_cb <= cb2;
      out_cr <= cr2;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_accept_enters_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> v1);

  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_luma) && $stable(out_cb) && $stable(out_cr)));

  assert_chroma_integer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && in_ready && cfx1 == 3'd0 && cfy1 == 3'd0) |=>
      (cb2[PIX_W-1:0] == $past(cb1[PIX_W-1:0]) &&
       cr2[3*PIX_W +: PIX_W] == $past(cr1[4*PIX_W +: PIX_W])));

  for (genvar gr = 0; gr < LW; gr++) begin : g_raw_row
    for (genvar gc = 0; gc < BK; gc++) begin : g_raw_col
      assert_raw_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> (raw2[gr][gc] >= -10 * PMAX && raw2[gr][gc] <= 42 * PMAX));
    end
  end
endmodule

// File: tb/mc_interp_tb_top.sv
module mc_interp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // {mode[15:14], fx[13:12], fy[11:10], cfx[9:7], cfy[6:4], seed[3:0]}
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 3'd0, 3'd0, 4'd1},
    {2'd0, 2'd1, 2'd0, 3'd1, 3'd0, 4'd2},
    {2'd0, 2'd2, 2'd0, 3'd2, 3'd1, 4'd3},
    {2'd0, 2'd3, 2'd0, 3'd3, 3'd2, 4'd4},
    {2'd0, 2'd0, 2'd1, 3'd4, 3'd3, 4'd5},
    {2'd0, 2'd1, 2'd1, 3'd5, 3'd4, 4'd6},
    {2'd0, 2'd2, 2'd1, 3'd6, 3'd5, 4'd7},
    {2'd0, 2'd3, 2'd1, 3'd7, 3'd6, 4'd8},
    {2'd0, 2'd0, 2'd2, 3'd0, 3'd7, 4'd9},
    {2'd0, 2'd1, 2'd2, 3'd3, 3'd0, 4'd10},
    {2'd0, 2'd2, 2'd2, 3'd5, 3'd2, 4'd11},
    {2'd0, 2'd3, 2'd2, 3'd7, 3'd4, 4'd12},
    {2'd0, 2'd0, 2'd3, 3'd2, 3'd6, 4'd13},
    {2'd0, 2'd1, 2'd3, 3'd4, 3'd1, 4'd14},
    {2'd0, 2'd2, 2'd3, 3'd6, 3'd3, 4'd15},
    {2'd0, 2'd3, 2'd3, 3'd1, 3'd5, 4'd0},
    {2'd1, 2'd2, 2'd2, 3'd7, 3'd7, 4'd0},
    {2'd2, 2'd2, 2'd2, 3'd4, 3'd4, 4'd0},
    {2'd2, 2'd1, 2'd3, 3'd3, 3'd5, 4'd0},
    {2'd3, 2'd3, 2'd1, 3'd1, 3'd6, 4'd0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_fx = '0, in_fy = '0;
  logic [647:0] in_luma_win = '0;
  logic [2:0]   in_cfx = '0, in_cfy = '0;
  logic [71:0]  in_cb_win = '0, in_cr_win = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_luma;
  logic [31:0]  out_cb, out_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_interp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fx(in_fx), .in_fy(in_fy), .in_luma_win(in_luma_win),
    .in_cfx(in_cfx), .in_cfy(in_cfy), .in_cb_win(in_cb_win), .in_cr_win(in_cr_win),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_luma(out_luma), .out_cb(out_cb), .out_cr(out_cr)
  );

  int lw [9][9];
  int cbw [3][3];
  int crw [3][3];
  int checks = 0;
  int errors = 0;
  int unsigned lcg;
  logic [127:0] e_luma, last_luma;
  logic [31:0]  e_cb, e_cr;

  function automatic int clipi(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction
  function automatic int t6(int a, int b, int c, int d, int e, int f);
    return a - 5*b + 20*c + 20*d - 5*e + f;
  endfunction
  function automatic int hraw(int r, int c);
    return t6(lw[r][c-2], lw[r][c-1], lw[r][c], lw[r][c+1], lw[r][c+2], lw[r][c+3]);
  endfunction
  function automatic int hb(int r, int c);
    return clipi((hraw(r, c) + 16) >>> 5);
  endfunction
  function automatic int hv(int r, int c);
    return clipi((t6(lw[r-2][c], lw[r-1][c], lw[r][c], lw[r+1][c], lw[r+2][c], lw[r+3][c]) + 16) >>> 5);
  endfunction
  function automatic int hj(int r, int c);
    return clipi((t6(hraw(r-2, c), hraw(r-1, c), hraw(r, c), hraw(r+1, c), hraw(r+2, c), hraw(r+3, c)) + 512) >>> 10);
  endfunction
  function automatic int mean(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic int luma_ref(int i, int j, int fx, int fy);
    int R, C, g, b, h, s, m, jj;
    R = i + 2; C = j + 2;
    g = lw[R][C]; b = hb(R, C); s = hb(R+1, C); h = hv(R, C); m = hv(R, C+1); jj = hj(R, C);
    case (fx*4 + fy)
      0:  return g;
      4:  return mean(g, b);
      8:  return b;
      12: return mean(lw[R][C+1], b);
      1:  return mean(g, h);
      5:  return mean(b, h);
      9:  return mean(b, jj);
      13: return mean(b, m);
      2:  return h;
      6:  return mean(h, jj);
      10: return jj;
      14: return mean(jj, m);
      3:  return mean(lw[R+1][C], h);
      7:  return mean(h, s);
      11: return mean(jj, s);
      default: return mean(m, s);
    endcase
  endfunction

  function automatic int chroma_ref(bit red, int i, int k, int dx, int dy);
    int a, b, c, d;
    if (red) begin a = crw[i][k]; b = crw[i][k+1]; c = crw[i+1][k]; d = crw[i+1][k+1]; end
    else     begin a = cbw[i][k]; b = cbw[i][k+1]; c = cbw[i+1][k]; d = cbw[i+1][k+1]; end
    return ((8-dx)*(8-dy)*a + dx*(8-dy)*b + (8-dx)*dy*c + dx*dy*d + 32) >> 6;
  endfunction

  function automatic string req_of(int fx, int fy);
    if (fx == 0 && fy == 0) return "R2/R7";
    if ((fx == 2 && fy == 0) || (fx == 0 && fy == 2)) return "R2/R3";
    if (fx == 2 && fy == 2) return "R2/R4";
    if (fx % 2 == 1 && fy % 2 == 1) return "R2/R6";
    return "R2/R5";
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic next_px(output int p);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    p = int'(lcg[23:16]);
  endtask

  task automatic fill(int mode, int seed);
    int p;
    lcg = seed * 7919 + 1;
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++) begin
        case (mode)
          0: begin next_px(p); lw[r][c] = p; end
          1: lw[r][c] = 255;
          2: lw[r][c] = ((r + c) % 2) ? 255 : 0;
          default: lw[r][c] = (c % 3 == 0) ? 255 : 0;
        endcase
      end
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        case (mode)
          0: begin next_px(p); cbw[r][c] = p; next_px(p); crw[r][c] = p; end
          1: begin cbw[r][c] = 255; crw[r][c] = 255; end
          2: begin cbw[r][c] = ((r + c) % 2) ? 255 : 0; crw[r][c] = 255 - cbw[r][c]; end
          default: begin cbw[r][c] = (c == 1) ? 255 : 0; crw[r][c] = (r == 1) ? 255 : 0; end
        endcase
      end
  endtask

  task automatic drive_pack(int fx, int fy, int cfx, int cfy);
    in_fx = 2'(fx); in_fy = 2'(fy); in_cfx = 3'(cfx); in_cfy = 3'(cfy);
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++)
        in_luma_win[(r*9+c)*8 +: 8] = 8'(lw[r][c]);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        in_cb_win[(r*3+c)*8 +: 8] = 8'(cbw[r][c]);
        in_cr_win[(r*3+c)*8 +: 8] = 8'(crw[r][c]);
      end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        e_luma[(i*4+j)*8 +: 8] = 8'(luma_ref(i, j, fx, fy));
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < 2; k++) begin
        e_cb[(i*2+k)*8 +: 8] = 8'(chroma_ref(1'b0, i, k, cfx, cfy));
        e_cr[(i*2+k)*8 +: 8] = 8'(chroma_ref(1'b1, i, k, cfx, cfy));
      end
  endtask

  task automatic run_one(string req);
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk(!out_valid, "R10 one edge after accept", 128'(out_valid), 128'(0));
    @(negedge clk);
    chk(!out_valid, "R10 two edges after accept", 128'(out_valid), 128'(0));
    @(negedge clk);
    chk(out_valid, "R10 three edges after accept", 128'(out_valid), 128'(1));
    chk(out_luma == e_luma, req, out_luma, e_luma);
    chk({out_cb, out_cr} == {e_cb, e_cr}, "R9 chroma", 128'({out_cb, out_cr}), 128'({e_cb, e_cr}));
    last_luma = out_luma;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [127:0] saved;
    logic [647:0] bl [3];
    logic [71:0]  bcb [3];
    logic [127:0] be [3];

    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1 during reset", 128'({out_valid, in_ready}), 128'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 after reset", 128'({out_valid, in_ready}), 128'(2'b01));

    for (int k = 0; k < NV; k++) begin
      fill(int'(VEC[k][15:14]), int'(VEC[k][3:0]) + 16 * k);
      drive_pack(int'(VEC[k][13:12]), int'(VEC[k][11:10]), int'(VEC[k][9:7]), int'(VEC[k][6:4]));
      run_one(req_of(int'(VEC[k][13:12]), int'(VEC[k][11:10])));
    end

    // R8: samples outside the needed window are ignored
    fill(0, 77);
    drive_pack(0, 0, 0, 0); run_one("R7");
    saved = last_luma;
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++)
        if (r < 2 || r > 5 || c < 2 || c > 5) lw[r][c] = 255 - lw[r][c];
    drive_pack(0, 0, 0, 0); run_one("R7");
    chk(last_luma == saved, "R8 integer outer ring", last_luma, saved);

    fill(0, 78);
    drive_pack(2, 0, 0, 0); run_one("R3");
    saved = last_luma;
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++)
        if (r < 2 || r > 5) lw[r][c] = 255 - lw[r][c];
    drive_pack(2, 0, 0, 0); run_one("R3");
    chk(last_luma == saved, "R8 horizontal half rows", last_luma, saved);

    fill(0, 79);
    drive_pack(0, 2, 0, 0); run_one("R3");
    saved = last_luma;
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 9; c++)
        if (c < 2 || c > 5) lw[r][c] = 255 - lw[r][c];
    drive_pack(0, 2, 0, 0); run_one("R3");
    chk(last_luma == saved, "R8 vertical half cols", last_luma, saved);

    // R11: back-pressure with a full pipeline
    for (int k = 0; k < 3; k++) begin
      fill(0, 90 + k);
      drive_pack(1, 2, 5, 2);
      bl[k] = in_luma_win; bcb[k] = in_cb_win; be[k] = e_luma;
    end
    @(negedge clk);
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_luma_win = bl[k]; in_cb_win = bcb[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(out_valid && !in_ready, "R11 full and stalled", 128'({out_valid, in_ready}), 128'(2'b10));
    repeat (4) @(negedge clk);
    chk(out_valid && out_luma == be[0], "R11 held during stall", out_luma, be[0]);
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid && out_luma == be[k], "R11 drain order", out_luma, be[k]);
      @(negedge clk);
    end
    chk(!out_valid, "R11 drained", 128'(out_valid), 128'(0));

    summary();
  end
endmodule